// File: doc/BRIEF.md
# Serial Overhead Row Capture Buffer

This block sits on the line side of a framer and collects the transport overhead that neighbouring logic streams in serially. On every rising edge of a free-running overhead clock where the enable is high, one data bit is taken. Bits are packed into bytes most significant bit first. One row of overhead is 36 bytes (twelve tributaries with three bytes each), so a complete row is exactly 288 enabled bits. The sender may pause briefly inside a row. An enable-low stretch of four overhead-clock cycles or more marks the end of a row's transfer.

Storage is two 36-byte banks. Serial data fills one bank while insertion logic reads the other through a byte-indexed port on the system clock. A one-cycle row pulse on the system clock swaps the two banks. As a result, the bytes that arrive while one row's payload is moving are what the insertion logic reads during the next row. At each swap the block reports whether the row just handed over held exactly 288 bits.

Top module: `ohrow_capture`

## Requirements
- R1: While `rst` is high at a system-clock edge, `row_err` and `rd_data` are 0 after that edge.
- R2: Byte k of a row (k = 0..35) is made of enabled bits 8k to 8k+7 in arrival order. The first of these eight bits becomes bit 7 of the byte.
- R3: The bank selected for reading changes only at a `row_pulse` edge. A row is captured between two pulses and is returned by `rd_data` after the second pulse. While the next row is being filled, a re-read of an earlier address returns the same byte.
- R4: Cycles where `oh_en` is low take no bit. A low stretch of up to three cycles inside a row leaves the row's bit count and byte packing unbroken.
- R5: At a `row_pulse` edge, `row_err` becomes 0 if the last transfer held exactly 288 enabled bits, and 1 if it held fewer or more.
- R6: At a `row_pulse` edge, `row_err` becomes 1 if no transfer ended (no low stretch of four cycles after at least one bit) since the previous pulse.
- R7: `rd_data` is 0 one system clock after `rd_addr` is 36 or higher.
- R8: Bits past the 288th in a transfer are discarded. The 36 stored bytes hold the first 288 bits.
- R9: `row_err` changes only at a system-clock edge where `row_pulse` is high.
- R10: `rd_data` shows the byte at `rd_addr` one system-clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock (read side, bank swap) |
| oh_clk | input | 1 | Free-running overhead serial clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| oh_en | input | 1 | Serial bit valid, sampled on `oh_clk` |
| oh_din | input | 1 | Serial overhead bit |
| row_pulse | input | 1 | One-cycle row boundary on `sys_clk`; swaps the banks |
| rd_addr | input | 6 | Byte index 0..35 into the bank being read |
| rd_data | output | 8 | Registered read byte |
| row_err | output | 1 | Length error of the row handed over at the last pulse |

## Verification
`row_err` is due on the same system-clock edge that samples `row_pulse`. The bench raises the pulse at a falling edge, drops it at the next falling edge, and reads the flag there. `rd_data` is due one edge after `rd_addr` changes, so each address is applied on one falling edge and its byte is compared on the following falling edge, while the next address goes out. Status from the overhead domain and the bank select cross through two-flop synchronizers. Before every pulse, the bench therefore waits eight idle overhead cycles plus four system cycles, and after a pulse it waits six overhead cycles before sending, so that no compare falls inside a crossing window.

// File: rtl/ohcap_pkg.sv
package ohcap_pkg;

    localparam int unsigned TRIBS         = 12;
    localparam int unsigned BYTES_PER_TRB = 3;
    localparam int unsigned ROW_BYTES     = TRIBS * BYTES_PER_TRB;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned GUARD_CYC     = 4;
    localparam int unsigned SYNC_STAGES   = 2;

    // status handed from the serial domain to the system domain
    typedef struct packed {
        logic tog;   // flips once per completed transfer
        logic ok;    // last transfer had the exact bit count
    } row_stat_t;

    function automatic int unsigned row_bits(input int unsigned nbytes);
        return nbytes * BYTE_W;
    endfunction

endpackage

// File: rtl/ohcap_sync.sv
module ohcap_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ohcap_deser.sv
module ohcap_deser
    import ohcap_pkg::*;
#(
    parameter int unsigned NBYTES = ROW_BYTES,
    parameter int unsigned GUARD  = GUARD_CYC,
    localparam int unsigned NBITS = row_bits(NBYTES),
    localparam int unsigned CNT_W = $clog2(NBITS + 2),
    localparam int unsigned AW    = $clog2(NBYTES),
    localparam int unsigned GW    = $clog2(GUARD + 1)
) (
    input  logic              oh_clk,
    input  logic              rst,
    input  logic              en,
    input  logic              din,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_byte,
    output row_stat_t         stat
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NBITS + 1);
    localparam logic [GW-1:0]    IDLE_END = GW'(GUARD - 1);
    localparam logic [GW-1:0]    IDLE_SAT = GW'(GUARD);

    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [GW-1:0]     idle_cnt;

    always_ff @(posedge oh_clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            idle_cnt <= '0;
            stat     <= '0;
        end else if (en) begin
            idle_cnt <= '0;
            shreg    <= {shreg[BYTE_W-3:0], din};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end else begin
            if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;
            if (idle_cnt == IDLE_END && bit_cnt != '0) begin
                stat.ok  <= (bit_cnt == CNT_FULL);
                stat.tog <= ~stat.tog;
                bit_cnt  <= '0;
            end
        end
    end

    // last bit of a byte goes straight into the write word
    assign wr_en   = en && (bit_cnt[2:0] == 3'd7) && (bit_cnt < CNT_FULL);
    assign wr_addr = AW'(bit_cnt >> 3);
    assign wr_byte = {shreg, din};
endmodule

// File: rtl/ohcap_banks.sv
module ohcap_banks
    import ohcap_pkg::*;
#(
    parameter int unsigned NBYTES = ROW_BYTES,
    localparam int unsigned AW    = $clog2(NBYTES)
) (
    input  logic              oh_clk,
    input  logic              wr_bank,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              sys_clk,
    input  logic              rst,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [2][NBYTES];

    always_ff @(posedge oh_clk) begin
        if (wr_en) mem[wr_bank][wr_addr] <= wr_byte;
    end

    always_ff @(posedge sys_clk) begin
        if (rst)                             rd_data <= '0;
        else if (rd_addr < AW'(NBYTES))      rd_data <= mem[rd_bank][rd_addr];
        else                                 rd_data <= '0;
    end
endmodule

// File: rtl/ohcap_ctrl.sv
module ohcap_ctrl
    import ohcap_pkg::*;
(
    input  logic      sys_clk,
    input  logic      rst,
    input  logic      row_pulse,
    input  row_stat_t stat_s,
    output logic      rd_sel,
    output logic      row_err
);
    logic tog_seen;

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            rd_sel   <= 1'b0;
            row_err  <= 1'b0;
            tog_seen <= 1'b0;
        end else if (row_pulse) begin
            rd_sel   <= ~rd_sel;
            row_err  <= !((stat_s.tog != tog_seen) && stat_s.ok);
            tog_seen <= stat_s.tog;
        end
    end
endmodule

// File: rtl/ohrow_capture.sv
module ohrow_capture
    import ohcap_pkg::*;
#(
    parameter int unsigned NBYTES = ROW_BYTES,
    parameter int unsigned GUARD  = GUARD_CYC,
    localparam int unsigned AW    = $clog2(NBYTES)
) (
    input  logic              sys_clk,
    input  logic              oh_clk,
    input  logic              rst,
    input  logic              oh_en,
    input  logic              oh_din,
    input  logic              row_pulse,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              row_err
);
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_byte;
    row_stat_t         stat_oh;
    row_stat_t         stat_sys;
    logic              rd_sel;
    logic              rd_sel_oh;

    ohcap_deser #(.NBYTES(NBYTES), .GUARD(GUARD)) u_deser (
        .oh_clk (oh_clk),
        .rst    (rst),
        .en     (oh_en),
        .din    (oh_din),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_byte(wr_byte),
        .stat   (stat_oh)
    );

    ohcap_sync #(.W($bits(row_stat_t)), .STAGES(SYNC_STAGES)) u_stat_sync (
        .clk(sys_clk),
        .rst(rst),
        .d  (stat_oh),
        .q  (stat_sys)
    );

    ohcap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(oh_clk),
        .rst(rst),
        .d  (rd_sel),
        .q  (rd_sel_oh)
    );

    ohcap_ctrl u_ctrl (
        .sys_clk  (sys_clk),
        .rst      (rst),
        .row_pulse(row_pulse),
        .stat_s   (stat_sys),
        .rd_sel   (rd_sel),
        .row_err  (row_err)
    );

    ohcap_banks #(.NBYTES(NBYTES)) u_banks (
        .oh_clk (oh_clk),
        .wr_bank(~rd_sel_oh),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_byte(wr_byte),
        .sys_clk(sys_clk),
        .rst    (rst),
        .rd_bank(rd_sel),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/ohrow_capture_chk.sv
module ohrow_capture_chk #(
    parameter int unsigned NBYTES = 36,
    parameter int unsigned AW     = 6
) (
    input logic          sys_clk,
    input logic          rst,
    input logic          row_pulse,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data,
    input logic          row_err,
    input logic          rd_sel
);
    AST_RESET_CLEARS: assert property (@(posedge sys_clk) $past(rst) |-> (row_err == 1'b0 && rd_data == 8'h00)); // R1
    AST_SEL_ONLY_ON_PULSE: assert property (@(posedge sys_clk) disable iff (rst) !row_pulse |=> $stable(rd_sel)); // R3
    AST_RANGE_READS_ZERO: assert property (@(posedge sys_clk) disable iff (rst) (rd_addr >= AW'(NBYTES)) |=> (rd_data == 8'h00)); // R7
    AST_ERR_ONLY_ON_PULSE: assert property (@(posedge sys_clk) disable iff (rst) !row_pulse |=> $stable(row_err)); // R9
endmodule

bind ohrow_capture ohrow_capture_chk #(.NBYTES(NBYTES), .AW(AW)) u_chk (
    .sys_clk  (sys_clk),
    .rst      (rst),
    .row_pulse(row_pulse),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .row_err  (row_err),
    .rd_sel   (rd_sel)
);

// File: tb/ohrow_capture_bench.sv
module ohrow_capture_bench;
    logic       sys_clk = 1'b0;
    logic       oh_clk  = 1'b0;
    logic       rst     = 1'b1;
    logic       oh_en   = 1'b0;
    logic       oh_din  = 1'b0;
    logic       row_pulse = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       row_err;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #5 sys_clk = ~sys_clk;   // 100 MHz
    always #7 oh_clk  = ~oh_clk;

    ohrow_capture u_ohrow_capture (
        .sys_clk(sys_clk), .oh_clk(oh_clk), .rst(rst),
        .oh_en(oh_en), .oh_din(oh_din), .row_pulse(row_pulse),
        .rd_addr(rd_addr), .rd_data(rd_data), .row_err(row_err)
    );

    function automatic logic [7:0] gen_byte(input int seed, input int k);
        return 8'((seed * 73 + k * 29 + (k >> 2) * 5 + 17) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // serial transfer of nbits bits from row "seed"; short low gaps inside (R4)
    task automatic send_row(input int seed, input int nbits);
        repeat (6) @(negedge oh_clk);
        for (int i = 0; i < nbits; i++) begin
            logic [7:0] b;
            b = gen_byte(seed, i / 8);
            oh_en  = 1'b1;
            oh_din = b[7 - (i % 8)];
            @(negedge oh_clk);
            if (i % 50 == 49) begin
                oh_en  = 1'b0;
                oh_din = ~oh_din;
                repeat (3) @(negedge oh_clk);
            end
        end
        oh_en  = 1'b0;
        oh_din = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge oh_clk);
        repeat (4) @(negedge sys_clk);
    endtask

    task automatic pulse(input int exp_err, input string req);
        @(negedge sys_clk);
        row_pulse = 1'b1;
        @(negedge sys_clk);
        row_pulse = 1'b0;
        check(req, int'(row_err), exp_err);
    endtask

    // pipelined reads compared every clock; error flag watched too (R9)
    task automatic read_row(input int seed, input int nbytes, input int exp_err, input string req);
        @(negedge sys_clk);
        rd_addr = 6'd0;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge sys_clk);
            check(req, int'(rd_data), int'(gen_byte(seed, i)));
            check("R9", int'(row_err), exp_err);
            rd_addr = 6'(i + 1);
        end
    endtask

    initial begin
        repeat (6) @(negedge oh_clk);
        @(negedge sys_clk);
        rst = 1'b0;
        check("R1 row_err", int'(row_err), 0);
        check("R1 rd_data", int'(rd_data), 0);

        pulse(1, "R6 no transfer");

        send_row(1, 288);
        settle();
        pulse(0, "R5 exact row");
        fork
            read_row(1, 36, 0, "R2 R10 row1");
            send_row(2, 288);
        join
        @(negedge sys_clk); rd_addr = 6'd5;
        @(negedge sys_clk);
        check("R3 hold while filling", int'(rd_data), int'(gen_byte(1, 5)));
        settle();
        pulse(0, "R5 second row");

        fork
            read_row(2, 36, 0, "R3 row2 after swap");
            send_row(3, 280);
        join
        settle();
        pulse(1, "R5 short row");
        fork
            read_row(3, 35, 1, "R2 short row bytes");
            send_row(4, 296);
        join
        settle();
        pulse(1, "R5 long row");
        read_row(4, 36, 1, "R8 first 288 kept");

        @(negedge sys_clk); rd_addr = 6'd36;
        @(negedge sys_clk);
        check("R7 addr 36", int'(rd_data), 0);
        rd_addr = 6'd63;
        @(negedge sys_clk);
        check("R7 addr 63", int'(rd_data), 0);

        settle();
        pulse(1, "R6 idle row");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sys_clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule